// File: doc/BRIEF.md
# 16-bit Word Arithmetic Unit

This unit does the 16-bit word operations of a byte-wide processor core. The accumulator pair YA (Y is the high byte, A the low byte) is combined with a word held in direct-page memory. A surrounding datapath fetches that word as two bytes. For the high byte the unit supplies the address: the low-byte address plus one, wrapped inside the 256-byte page.

There are five operations. Add-word, subtract-word and compare-word take YA together with the memory word. Increment-word and decrement-word change the memory word itself. The caller gives a one-cycle start strobe with the opcode, both operand pairs, the page address and the current flags. One cycle later the unit pulses `done`. With the pulse it shows the 16-bit result, write enables that say whether the result goes to YA or to memory, and the updated N, V, H, Z and C flags. Flags that an operation does not touch are passed through from `flags_in`.

Top module: `word_alu16`

## Requirements
- R1: `hi_addr` equals (`dp_addr` + 1) modulo 256 at all times, so address 0xFF gives 0x00.
- R2: A cycle with `start` high makes `done` high for exactly the next cycle. `res_word`, `flags_out`, `wr_ya` and `wr_mem` are registered and valid in that cycle. After reset all outputs are 0.
- R3: Opcode 0 (add-word) gives `res_word` = YA + W modulo 65536, sets C to the carry out of bit 15, and raises `wr_ya`. W is {`mem_hi`,`mem_lo`} and YA is {`acc_hi`,`acc_lo`}.
- R4: Opcode 1 (subtract-word) adds the two's complement of W to YA, computed as YA + ~W + 1. C is the carry out of bit 15, so C=1 means no borrow; W=0 gives C=1. It raises `wr_ya`.
- R5: For opcodes 0–4, N is bit 15 of the result, and Z is 1 only when all 16 result bits are zero.
- R6: For opcodes 0 and 1, V is set when the sign of the operand equals the sign of the original Y, and the sign of the result differs from it. For opcode 1 the operand is the negated W.
- R7: For opcodes 0 and 1, H is the carry out of bit 11 of the 16-bit addition.
- R8: Opcode 2 (compare-word) computes N, Z and C as opcode 1 does. It passes V and H from `flags_in` and raises neither `wr_ya` nor `wr_mem`.
- R9: Opcodes 3 (increment-word) and 4 (decrement-word) give W+1 and W−1 modulo 65536, with the carry or borrow from the low byte reaching the high byte. They raise `wr_mem` only and pass C, V and H from `flags_in`.
- R10: Opcodes 5–7 raise `done` but raise no write enable, and `flags_out` equals `flags_in`.
- R11: Flag bit positions in `flags_in` and `flags_out` are: 4 = N, 3 = V, 2 = H, 1 = Z, 0 = C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 3 | Operation code (0 add, 1 sub, 2 cmp, 3 inc, 4 dec) |
| acc_lo | input | 8 | A register (low byte of YA) |
| acc_hi | input | 8 | Y register (high byte of YA) |
| mem_lo | input | 8 | Memory word low byte |
| mem_hi | input | 8 | Memory word high byte |
| dp_addr | input | 8 | Page offset of the low byte |
| flags_in | input | 5 | Current flags {N,V,H,Z,C} |
| hi_addr | output | 8 | Page offset of the high byte |
| done | output | 1 | Result valid pulse |
| res_word | output | 16 | Result word |
| wr_ya | output | 1 | Result goes to YA |
| wr_mem | output | 1 | Result goes to the memory word |
| flags_out | output | 5 | Updated flags {N,V,H,Z,C} |

## Verification
`hi_addr` is combinational. It is checked in the same low clock phase in which `dp_addr` is driven. Every other result comes from one register stage. The bench raises `start` on a falling edge, and the rising edge that follows captures the operation. The bench reads `done`, `res_word`, the write enables and the flags at the next falling edge, half a cycle after that capture. For directed cases it also checks one falling edge later that `done` has dropped.

// File: rtl/wordalu_pkg.sv
// Package: shared opcode and flag-position definitions for the word unit.
// Assumes opcodes arrive on a 3-bit field; unlisted codes are no-ops.
package wordalu_pkg;
    typedef enum logic [2:0] {
        WOP_ADD = 3'd0,
        WOP_SUB = 3'd1,
        WOP_CMP = 3'd2,
        WOP_INC = 3'd3,
        WOP_DEC = 3'd4
    } wop_e;

    localparam int FLAG_W = 5;
    localparam int FL_C = 0;
    localparam int FL_Z = 1;
    localparam int FL_H = 2;
    localparam int FL_V = 3;
    localparam int FL_N = 4;
endpackage

// File: rtl/wa_lane.sv
// Byte lane adder split into two nibbles so the mid-lane carry is visible.
// Assumes an even lane width.
module wa_lane #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              ci,
    output logic [LANE_W-1:0] s,
    output logic              c_mid,
    output logic              co
);
    localparam int NIB_W = LANE_W / 2;

    logic [NIB_W:0] lo_sum;
    logic [NIB_W:0] hi_sum;

    // Two chained nibble additions.
    always_comb begin
        lo_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
        hi_sum = {1'b0, a[LANE_W-1:NIB_W]} + {1'b0, b[LANE_W-1:NIB_W]}
               + {{NIB_W{1'b0}}, lo_sum[NIB_W]};
    end

    assign s     = {hi_sum[NIB_W-1:0], lo_sum[NIB_W-1:0]};
    assign c_mid = lo_sum[NIB_W];
    assign co    = hi_sum[NIB_W];
endmodule

// File: rtl/wa_operand.sv
// Chooses the base word, addend and carry-in for each operation.
// Subtraction uses base + ~W + 1; inc/dec add +1 / all-ones to the memory word.
module wa_operand
    import wordalu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] acc_word,
    input  logic [WORD_W-1:0] mem_word,
    output logic [WORD_W-1:0] base,
    output logic [WORD_W-1:0] addend,
    output logic              cin,
    output logic              op_sign
);
    logic [WORD_W-1:0] neg_word;

    assign neg_word = ~mem_word + {{(WORD_W-1){1'b0}}, 1'b1};

    // Operand selection per opcode.
    always_comb begin
        base    = acc_word;
        addend  = '0;
        cin     = 1'b0;
        op_sign = mem_word[WORD_W-1];
        case (op)
            WOP_ADD: addend = mem_word;
            WOP_SUB, WOP_CMP: begin
                addend  = ~mem_word;
                cin     = 1'b1;
                op_sign = neg_word[WORD_W-1];
            end
            WOP_INC: begin
                base   = mem_word;
                addend = {{(WORD_W-1){1'b0}}, 1'b1};
            end
            WOP_DEC: begin
                base   = mem_word;
                addend = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wa_adder.sv
// Word adder built from byte lanes; exposes the carry out of the top lane's
// low nibble (half carry) and of the top lane (word carry).
module wa_adder #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic [LANES*LANE_W-1:0] a,
    input  logic [LANES*LANE_W-1:0] b,
    input  logic                    ci,
    output logic [LANES*LANE_W-1:0] sum,
    output logic                    half_c,
    output logic                    c_out
);
    logic [LANES:0]   chain;
    logic [LANES-1:0] mids;

    assign chain[0] = ci;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        wa_lane #(.LANE_W(LANE_W)) u_lane (
            .a     (a[i*LANE_W +: LANE_W]),
            .b     (b[i*LANE_W +: LANE_W]),
            .ci    (chain[i]),
            .s     (sum[i*LANE_W +: LANE_W]),
            .c_mid (mids[i]),
            .co    (chain[i+1])
        );
    end

    assign half_c = mids[LANES-1];
    assign c_out  = chain[LANES];
endmodule

// File: rtl/wa_flags.sv
// Builds the next flag set and write enables; untouched flags pass through.
// Assumes base[MSB] is the original Y sign for YA operations.
module wa_flags
    import wordalu_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] sum,
    input  logic              op_sign,
    input  logic              half_c,
    input  logic              c_out,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [FLAG_W-1:0] flags_nxt,
    output logic              wr_ya_nxt,
    output logic              wr_mem_nxt
);
    logic res_n, res_z, res_v;

    assign res_n = sum[WORD_W-1];
    assign res_z = (sum == '0);
    assign res_v = (op_sign == base[WORD_W-1]) && (sum[WORD_W-1] != base[WORD_W-1]);

    // Per-opcode flag update and destination choice.
    always_comb begin
        flags_nxt  = flags_in;
        wr_ya_nxt  = 1'b0;
        wr_mem_nxt = 1'b0;
        case (op)
            WOP_ADD, WOP_SUB: begin
                flags_nxt[FL_N] = res_n;
                flags_nxt[FL_Z] = res_z;
                flags_nxt[FL_C] = c_out;
                flags_nxt[FL_V] = res_v;
                flags_nxt[FL_H] = half_c;
                wr_ya_nxt       = 1'b1;
            end
            WOP_CMP: begin
                flags_nxt[FL_N] = res_n;
                flags_nxt[FL_Z] = res_z;
                flags_nxt[FL_C] = c_out;
            end
            WOP_INC, WOP_DEC: begin
                flags_nxt[FL_N] = res_n;
                flags_nxt[FL_Z] = res_z;
                wr_mem_nxt      = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/word_alu16.sv
// Top of the 16-bit word unit: operand select, lane adder, flag logic and
// one output register stage. Computes the wrapped high-byte page address.
// Assumes start is a single-cycle strobe with operands stable in that cycle.
module word_alu16
    import wordalu_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          op,
    input  logic [BYTE_W-1:0]   acc_lo,
    input  logic [BYTE_W-1:0]   acc_hi,
    input  logic [BYTE_W-1:0]   mem_lo,
    input  logic [BYTE_W-1:0]   mem_hi,
    input  logic [BYTE_W-1:0]   dp_addr,
    input  logic [FLAG_W-1:0]   flags_in,
    output logic [BYTE_W-1:0]   hi_addr,
    output logic                done,
    output logic [2*BYTE_W-1:0] res_word,
    output logic                wr_ya,
    output logic                wr_mem,
    output logic [FLAG_W-1:0]   flags_out
);
    localparam int WORD_W = 2 * BYTE_W;

    logic [WORD_W-1:0] base, addend, sum;
    logic              cin, op_sign, half_c, c_out;
    logic [FLAG_W-1:0] flags_nxt;
    logic              wr_ya_nxt, wr_mem_nxt;

    assign hi_addr = dp_addr + {{(BYTE_W-1){1'b0}}, 1'b1};

    wa_operand #(.WORD_W(WORD_W)) u_operand (
        .op       (op),
        .acc_word ({acc_hi, acc_lo}),
        .mem_word ({mem_hi, mem_lo}),
        .base     (base),
        .addend   (addend),
        .cin      (cin),
        .op_sign  (op_sign)
    );

    wa_adder #(.LANE_W(BYTE_W), .LANES(2)) u_adder (
        .a      (base),
        .b      (addend),
        .ci     (cin),
        .sum    (sum),
        .half_c (half_c),
        .c_out  (c_out)
    );

    wa_flags #(.WORD_W(WORD_W)) u_flags (
        .op         (op),
        .base       (base),
        .sum        (sum),
        .op_sign    (op_sign),
        .half_c     (half_c),
        .c_out      (c_out),
        .flags_in   (flags_in),
        .flags_nxt  (flags_nxt),
        .wr_ya_nxt  (wr_ya_nxt),
        .wr_mem_nxt (wr_mem_nxt)
    );

    // Output register stage: capture results on start, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            res_word  <= '0;
            wr_ya     <= 1'b0;
            wr_mem    <= 1'b0;
            flags_out <= '0;
        end else begin
            done   <= start;
            wr_ya  <= start && wr_ya_nxt;
            wr_mem <= start && wr_mem_nxt;
            if (start) begin
                res_word  <= sum;
                flags_out <= flags_nxt;
            end
        end
    end

    // R2
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R8
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == WOP_CMP) |=> (!wr_ya && !wr_mem));

    // R9
    incdec_keep_cvh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == WOP_INC || op == WOP_DEC)) |=>
        (flags_out[FL_C] == $past(flags_in[FL_C]) &&
         flags_out[FL_V] == $past(flags_in[FL_V]) &&
         flags_out[FL_H] == $past(flags_in[FL_H])));

    // R5
    nz_match_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (wr_ya || wr_mem)) |->
        (flags_out[FL_Z] == (res_word == '0) && flags_out[FL_N] == res_word[WORD_W-1]));

    // R10
    bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op > 3'd4) |=> (!wr_ya && !wr_mem && flags_out == $past(flags_in)));
endmodule

// File: tb/word_alu16_tb.sv
module word_alu16_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [7:0]  acc_lo = 8'd0, acc_hi = 8'd0, mem_lo = 8'd0, mem_hi = 8'd0, dp_addr = 8'd0;
    logic [4:0]  flags_in = 5'd0;
    logic [7:0]  hi_addr;
    logic        done, wr_ya, wr_mem;
    logic [15:0] res_word;
    logic [4:0]  flags_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    word_alu16 u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .mem_lo(mem_lo), .mem_hi(mem_hi),
        .dp_addr(dp_addr), .flags_in(flags_in), .hi_addr(hi_addr), .done(done),
        .res_word(res_word), .wr_ya(wr_ya), .wr_mem(wr_mem), .flags_out(flags_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected {wr_ya, wr_mem, flags[4:0], result[15:0]} from the requirements.
    function automatic logic [22:0] model(input logic [2:0] o, input logic [7:0] a, input logic [7:0] y,
                                          input logic [7:0] lo, input logic [7:0] hi, input logic [4:0] fin);
        logic [15:0] ya, w, bs, ad, res, negw;
        logic        ci, c, h, v, sgn;
        logic [16:0] full;
        logic [8:0]  lo9;
        logic [4:0]  h5, f;
        logic        wy, wm;
        ya = {y, a}; w = {hi, lo}; negw = ~w + 16'd1;
        bs = ya; ad = 16'd0; ci = 1'b0; sgn = w[15];
        case (o)
            3'd0: ad = w;
            3'd1, 3'd2: begin ad = ~w; ci = 1'b1; sgn = negw[15]; end
            3'd3: begin bs = w; ad = 16'd1; end
            3'd4: begin bs = w; ad = 16'hFFFF; end
            default: ;
        endcase
        full = {1'b0, bs} + {1'b0, ad} + {16'd0, ci};
        res = full[15:0]; c = full[16];
        lo9 = {1'b0, bs[7:0]} + {1'b0, ad[7:0]} + {8'd0, ci};
        h5 = {1'b0, bs[11:8]} + {1'b0, ad[11:8]} + {4'd0, lo9[8]};
        h = h5[4];
        v = (sgn == y[7]) && (res[15] != y[7]);
        f = fin; wy = 1'b0; wm = 1'b0;
        case (o)
            3'd0, 3'd1: begin f = {res[15], v, h, res == 16'd0, c}; wy = 1'b1; end
            3'd2: begin f[4] = res[15]; f[1] = (res == 16'd0); f[0] = c; end
            3'd3, 3'd4: begin f[4] = res[15]; f[1] = (res == 16'd0); wm = 1'b1; end
            default: ;
        endcase
        return {wy, wm, f, res};
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'd0: return "R3/R5/R6/R7";
            3'd1: return "R4/R5/R6/R7";
            3'd2: return "R8";
            3'd3, 3'd4: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [15:0] yav, input logic [15:0] wv,
                          input logic [4:0] fin, input bit chk_drop);
        logic [22:0] e;
        @(negedge clk);
        op = o; acc_hi = yav[15:8]; acc_lo = yav[7:0];
        mem_hi = wv[15:8]; mem_lo = wv[7:0]; flags_in = fin; start = 1'b1;
        e = model(o, yav[7:0], yav[15:8], wv[7:0], wv[15:8], fin);
        @(negedge clk);
        start = 1'b0;
        chk("R2 done", {31'd0, done}, 32'd1);
        if (o <= 3'd4) chk({req_of(o), " result"}, {16'd0, res_word}, {16'd0, e[15:0]});
        chk({req_of(o), " R11 flags"}, {27'd0, flags_out}, {27'd0, e[20:16]});
        chk({req_of(o), " writes"}, {30'd0, wr_ya, wr_mem}, {30'd0, e[22:21]});
        if (chk_drop) begin
            @(negedge clk);
            chk("R2 done drop", {31'd0, done}, 32'd0);
        end
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset state", {8'd0, done, wr_ya, wr_mem, flags_out, res_word},
            {8'd0, 1'b0, 1'b0, 1'b0, 5'd0, 16'd0});

        // R1 page wrap of the high-byte address
        dp_addr = 8'h3C; #1 chk("R1 hi_addr", {24'd0, hi_addr}, 32'h3D);
        dp_addr = 8'hFF; #1 chk("R1 hi_addr wrap", {24'd0, hi_addr}, 32'h00);

        run_op(3'd0, 16'hFFFF, 16'h0001, 5'd0, 1'b1);  // R3 carry out, zero, half carry
        run_op(3'd0, 16'h7FFF, 16'h0001, 5'd0, 1'b1);  // R6 positive overflow
        run_op(3'd0, 16'h1234, 16'h0F0F, 5'h1F, 1'b0); // R7 half carry from bit 11
        run_op(3'd1, 16'h0000, 16'h0001, 5'd0, 1'b1);  // R4 borrow
        run_op(3'd1, 16'h4321, 16'h0000, 5'd0, 1'b0);  // R4 W=0 keeps C=1
        run_op(3'd1, 16'h8000, 16'h0001, 5'd0, 1'b0);  // R6 negative overflow
        run_op(3'd1, 16'h0000, 16'h8000, 5'd0, 1'b0);  // R6 negated 0x8000
        run_op(3'd2, 16'h5A5A, 16'h5A5A, 5'h0C, 1'b1); // R8 equal, V/H kept
        run_op(3'd2, 16'h0001, 16'h0002, 5'h00, 1'b0); // R8 less-than
        run_op(3'd3, 16'h0000, 16'h00FF, 5'h0D, 1'b0); // R9 carry into high byte
        run_op(3'd3, 16'h0000, 16'hFFFF, 5'h00, 1'b0); // R9 wrap to zero
        run_op(3'd4, 16'h0000, 16'h0100, 5'h0D, 1'b0); // R9 borrow from high byte
        run_op(3'd4, 16'h0000, 16'h0000, 5'h00, 1'b1); // R9 wrap to 0xFFFF
        run_op(3'd5, 16'h1111, 16'h2222, 5'h15, 1'b1); // R10 unused opcode
        run_op(3'd7, 16'h0000, 16'h0000, 5'h0A, 1'b0); // R10 unused opcode

        for (int i = 0; i < 400; i++) begin
            logic [2:0] ro;
            ro = 3'($urandom_range(0, 7));
            dp_addr = 8'($urandom);
            #1 chk("R1 hi_addr rand", {24'd0, hi_addr}, {24'd0, dp_addr + 8'd1});
            run_op(ro, 16'($urandom), 16'($urandom), 5'($urandom), (i % 16) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule